// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by reading two levels of page tables held in memory. The address is split into three fields. The top 10 bits index a directory table whose base comes from a root-pointer register. The middle 10 bits index the second-level table that the directory entry points to. The low 12 bits pass through unchanged as the offset inside a 4 KB frame.

Table entries are 32-bit words. Bits [31:12] hold the base of the next table or of the frame, and bit 0 marks the entry as present. An absent entry at either level ends the walk with a fault, and the fault reports which level it came from. The block has a single read port to memory and issues one read at a time. The reply may come back any number of cycles after the request, so the walker works behind caches, arbiters or slow memories.

The walker takes one request at a time. It is ready only while idle and gives a single-cycle response pulse at the end of each walk. Software loads the root pointer through a write strobe, and each later walk uses the new value.

Top module: `pt2_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` and `mem_rd_req` are 0.
- R2: When a request is accepted, the next cycle carries a one-cycle `mem_rd_req` at address {root[31:12], 12'h000} + 4·vaddr[31:22]. Bits [11:0] of the root write data have no effect on this address.
- R3: After a present directory entry E1 is returned, the next cycle carries a one-cycle `mem_rd_req` at {E1[31:12], 12'h000} + 4·vaddr[21:12].
- R4: After a present second-level entry E2 is returned, the next cycle carries a one-cycle `resp_valid` with `resp_fault`=0 and `resp_paddr` = {E2[31:12], vaddr[11:0]}.
- R5: A directory entry with bit 0 = 0 gives, in the next cycle, `resp_valid`=1, `resp_fault`=1, `resp_fault_lvl`=0 and `resp_paddr`=0, and no second read is issued.
- R6: A second-level entry with bit 0 = 0 gives, in the next cycle, `resp_valid`=1, `resp_fault`=1, `resp_fault_lvl`=1 and `resp_paddr`=0.
- R7: The walker waits any number of cycles for `mem_rd_valid`. A `mem_rd_valid` pulse that arrives while no read is pending causes no response and no read.
- R8: `req_ready` is 0 from the cycle after acceptance through the response cycle, and is 1 again in the cycle that follows. A request presented while the walker is busy starts no walk.
- R9: Entry bits [11:1] have no effect on the next address, on the physical address or on the fault decision.
- R10: A root write sets the directory base used by every later walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Logical address to translate |
| req_ready | output | 1 | Walker idle and able to take a request |
| root_wr_en | input | 1 | Write strobe for the root pointer |
| root_wr_data | input | 32 | New root pointer; bits [31:12] are kept |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_rd_addr | output | 32 | Byte address of the table entry to read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Table entry word |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_paddr | output | 32 | Physical address (0 on a fault) |
| resp_fault | output | 1 | Walk ended on an absent entry |
| resp_fault_lvl | output | 1 | Level of the fault: 0 directory, 1 second level |

## Verification
The bench uses both extremes of each index field (all zeros and all ones) and entries with junk in bits [11:1]. A design that swapped the index fields, forgot the shift by two, or let the junk bits leak would issue the wrong read addresses. Absent entries at each level check the fault level, and after a directory fault the bench checks that no second read appears, which catches a walker that reads on anyway. Long latencies, stray read replies while idle and requests presented while busy catch walkers that respond to data they never asked for or that restart in the middle of a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_DIR   = 3'd1,
    ST_WT_DIR   = 3'd2,
    ST_RD_LEAF  = 3'd3,
    ST_WT_LEAF  = 3'd4,
    ST_DONE     = 3'd5,
    ST_FAULT    = 3'd6
  } walk_state_e;

  typedef enum logic {
    LVL_DIR  = 1'b0,
    LVL_LEAF = 1'b1
  } walk_lvl_e;

endpackage

// File: rtl/ptw_root_reg.sv
module ptw_root_reg #(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_data,
  output logic [AW-OFF_W-1:0] base_pfn
);
  localparam int unsigned PFN_W = AW - OFF_W;

  logic [PFN_W-1:0] pfn_q;
  logic             unused_low;

  assign unused_low = ^wr_data[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pfn_q <= '0;
    end else if (wr_en) begin
      pfn_q <= wr_data[AW-1:OFF_W];
    end
  end

  assign base_pfn = pfn_q;

  // R10: a root write is visible on the following cycle
  a_r10_root_load: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (base_pfn == $past(wr_data[AW-1:OFF_W])));

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned AW        = 32,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned ENT_SHIFT = 2
) (
  input  logic                sel_leaf,
  input  logic [AW-OFF_W-1:0] root_pfn,
  input  logic [AW-OFF_W-1:0] table_pfn,
  input  logic [AW-1:0]       va_new,
  input  logic [AW-1:0]       va_held,
  output logic [AW-1:0]       entry_addr
);
  localparam int unsigned PFN_W = AW - OFF_W;
  localparam int unsigned PAD_W = AW - IDX_W - ENT_SHIFT;
  localparam int unsigned DIR_LO  = OFF_W + IDX_W;
  localparam int unsigned LEAF_LO = OFF_W;

  logic [PFN_W-1:0] base_pfn;
  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    base_byte;
  logic [AW-1:0]    idx_byte;
  logic             unused_va;

  assign unused_va = ^{va_new[DIR_LO-1:0], va_held[AW-1:DIR_LO], va_held[OFF_W-1:0]};

  always_comb begin
    if (sel_leaf) begin
      base_pfn = table_pfn;
      idx      = va_held[LEAF_LO +: IDX_W];
    end else begin
      base_pfn = root_pfn;
      idx      = va_new[DIR_LO +: IDX_W];
    end
    base_byte  = {base_pfn, {OFF_W{1'b0}}};
    idx_byte   = {{PAD_W{1'b0}}, idx, {ENT_SHIFT{1'b0}}};
    entry_addr = base_byte + idx_byte;
  end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [AW-1:0]       req_vaddr,
  output logic                req_ready,
  input  logic                mem_rd_valid,
  input  logic [AW-1:0]       mem_rd_data,
  input  logic [AW-1:0]       next_addr,
  output logic                sel_leaf,
  output logic [AW-1:0]       va_held,
  output logic                mem_rd_req,
  output logic [AW-1:0]       mem_rd_addr,
  output logic                resp_valid,
  output logic [AW-1:0]       resp_paddr,
  output logic                resp_fault,
  output logic                resp_fault_lvl
);
  localparam int unsigned PFN_W = AW - OFF_W;

  walk_state_e      state_q;
  logic [AW-1:0]    va_q;
  logic             rd_req_q;
  logic [AW-1:0]    rd_addr_q;
  logic             rsp_v_q;
  logic [AW-1:0]    rsp_pa_q;
  logic             rsp_f_q;
  walk_lvl_e        rsp_lvl_q;
  logic             ent_present;
  logic [PFN_W-1:0] ent_pfn;
  logic             unused_flags;

  assign ent_present  = mem_rd_data[0];
  assign ent_pfn      = mem_rd_data[AW-1:OFF_W];
  assign unused_flags = ^mem_rd_data[OFF_W-1:1];

  assign sel_leaf = (state_q == ST_WT_DIR);
  assign va_held  = va_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      va_q      <= '0;
      rd_req_q  <= 1'b0;
      rd_addr_q <= '0;
      rsp_v_q   <= 1'b0;
      rsp_pa_q  <= '0;
      rsp_f_q   <= 1'b0;
      rsp_lvl_q <= LVL_DIR;
    end else begin
      rd_req_q <= 1'b0;
      rsp_v_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q      <= req_vaddr;
            rd_req_q  <= 1'b1;
            rd_addr_q <= next_addr;
            state_q   <= ST_RD_DIR;
          end
        end
        ST_RD_DIR:  state_q <= ST_WT_DIR;
        ST_WT_DIR: begin
          if (mem_rd_valid) begin
            if (ent_present) begin
              rd_req_q  <= 1'b1;
              rd_addr_q <= next_addr;
              state_q   <= ST_RD_LEAF;
            end else begin
              rsp_v_q   <= 1'b1;
              rsp_f_q   <= 1'b1;
              rsp_lvl_q <= LVL_DIR;
              rsp_pa_q  <= '0;
              state_q   <= ST_FAULT;
            end
          end
        end
        ST_RD_LEAF: state_q <= ST_WT_LEAF;
        ST_WT_LEAF: begin
          if (mem_rd_valid) begin
            rsp_v_q <= 1'b1;
            if (ent_present) begin
              rsp_f_q   <= 1'b0;
              rsp_lvl_q <= LVL_DIR;
              rsp_pa_q  <= {ent_pfn, va_q[OFF_W-1:0]};
              state_q   <= ST_DONE;
            end else begin
              rsp_f_q   <= 1'b1;
              rsp_lvl_q <= LVL_LEAF;
              rsp_pa_q  <= '0;
              state_q   <= ST_FAULT;
            end
          end
        end
        ST_DONE, ST_FAULT: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready      = (state_q == ST_IDLE);
  assign mem_rd_req     = rd_req_q;
  assign mem_rd_addr    = rd_addr_q;
  assign resp_valid     = rsp_v_q;
  assign resp_paddr     = rsp_pa_q;
  assign resp_fault     = rsp_f_q;
  assign resp_fault_lvl = rsp_lvl_q;

  // R2, R3: each table read is a single-cycle request
  a_r2_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> !mem_rd_req);

  // R4: the response is a single-cycle pulse
  a_r4_resp_pulse: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R4: a good translation keeps the request offset
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_fault) |-> (resp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

  // R5, R6: faults report a zero physical address
  a_r5_fault_zero: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault) |-> (resp_paddr == '0));

  // R8: the walker is busy while a read is outstanding
  a_r8_busy_on_read: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> !req_ready);

  // R8: ready again right after a response
  a_r8_ready_after: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> req_ready);

  // R7: a read is never issued in the same cycle as a response
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> !mem_rd_req);

endmodule

// File: rtl/pt2_walker.sv
module pt2_walker #(
  parameter int unsigned AW        = 32,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned ENT_SHIFT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  output logic          req_ready,
  input  logic          root_wr_en,
  input  logic [AW-1:0] root_wr_data,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_valid,
  input  logic [AW-1:0] mem_rd_data,
  output logic          resp_valid,
  output logic [AW-1:0] resp_paddr,
  output logic          resp_fault,
  output logic          resp_fault_lvl
);
  localparam int unsigned PFN_W = AW - OFF_W;

  logic [PFN_W-1:0] root_pfn;
  logic [AW-1:0]    next_addr;
  logic             sel_leaf;
  logic [AW-1:0]    va_held;

  ptw_root_reg #(.AW(AW), .OFF_W(OFF_W)) u_root (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (root_wr_en),
    .wr_data  (root_wr_data),
    .base_pfn (root_pfn)
  );

  ptw_addr_gen #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENT_SHIFT(ENT_SHIFT)) u_agen (
    .sel_leaf   (sel_leaf),
    .root_pfn   (root_pfn),
    .table_pfn  (mem_rd_data[AW-1:OFF_W]),
    .va_new     (req_vaddr),
    .va_held    (va_held),
    .entry_addr (next_addr)
  );

  ptw_ctrl #(.AW(AW), .OFF_W(OFF_W)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_vaddr      (req_vaddr),
    .req_ready      (req_ready),
    .mem_rd_valid   (mem_rd_valid),
    .mem_rd_data    (mem_rd_data),
    .next_addr      (next_addr),
    .sel_leaf       (sel_leaf),
    .va_held        (va_held),
    .mem_rd_req     (mem_rd_req),
    .mem_rd_addr    (mem_rd_addr),
    .resp_valid     (resp_valid),
    .resp_paddr     (resp_paddr),
    .resp_fault     (resp_fault),
    .resp_fault_lvl (resp_fault_lvl)
  );

  // R1: idle walker after reset is ready and silent
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!resp_valid && !mem_rd_req));

endmodule

// File: tb/pt2_walker_tb.sv
`timescale 1ns/1ps
module pt2_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        root_wr_en = 1'b0;
  logic [31:0] root_wr_data = '0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        resp_valid;
  logic [31:0] resp_paddr;
  logic        resp_fault;
  logic        resp_fault_lvl;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] root_m = '0;

  always #4 clk = ~clk;

  pt2_walker dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .root_wr_en(root_wr_en), .root_wr_data(root_wr_data),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_fault(resp_fault), .resp_fault_lvl(resp_fault_lvl)
  );

  function automatic logic [31:0] exp_dir(logic [31:0] root, logic [31:0] va);
    return {root[31:12], 12'h000} + {20'h0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] exp_leaf(logic [31:0] e1, logic [31:0] va);
    return {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
  endfunction

  function automatic logic [31:0] exp_pa(logic [31:0] e2, logic [31:0] va);
    return {e2[31:12], va[11:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_root(logic [31:0] v);
    @(negedge clk);
    root_wr_en = 1'b1; root_wr_data = v;
    @(negedge clk);
    root_wr_en = 1'b0; root_wr_data = 32'hDEAD_BEEF;
    root_m = v;
  endtask

  task automatic walk(logic [31:0] va, logic [31:0] e1, logic [31:0] e2,
                      int l1, int l2, bit poke);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 dir read req", {31'h0, mem_rd_req}, 32'd1);
    chk("R2 dir read addr", mem_rd_addr, exp_dir(root_m, va));
    chk("R8 busy after accept", {31'h0, req_ready}, 32'd0);
    if (poke) begin
      req_valid = 1'b1; req_vaddr = ~va;
    end
    repeat (l1) @(negedge clk);
    chk("R2 single dir read", {31'h0, mem_rd_req}, 32'd0);
    mem_rd_valid = 1'b1; mem_rd_data = e1;
    @(negedge clk);
    mem_rd_valid = 1'b0; mem_rd_data = $urandom;
    if (e1[0]) begin
      chk("R3 leaf read req", {31'h0, mem_rd_req}, 32'd1);
      chk("R3 leaf read addr", mem_rd_addr, exp_leaf(e1, va));
      chk("R7 no early resp", {31'h0, resp_valid}, 32'd0);
      repeat (l2) @(negedge clk);
      chk("R8 busy in walk", {31'h0, req_ready}, 32'd0);
      mem_rd_valid = 1'b1; mem_rd_data = e2;
      @(negedge clk);
      mem_rd_valid = 1'b0; mem_rd_data = $urandom;
      chk("R4 resp valid", {31'h0, resp_valid}, 32'd1);
      if (e2[0]) begin
        chk("R4 fault flag", {31'h0, resp_fault}, 32'd0);
        chk("R4 paddr", resp_paddr, exp_pa(e2, va));
      end else begin
        chk("R6 fault flag", {31'h0, resp_fault}, 32'd1);
        chk("R6 fault level", {31'h0, resp_fault_lvl}, 32'd1);
        chk("R6 paddr zero", resp_paddr, 32'd0);
      end
    end else begin
      chk("R5 resp valid", {31'h0, resp_valid}, 32'd1);
      chk("R5 fault flag", {31'h0, resp_fault}, 32'd1);
      chk("R5 fault level", {31'h0, resp_fault_lvl}, 32'd0);
      chk("R5 paddr zero", resp_paddr, 32'd0);
      chk("R5 no leaf read", {31'h0, mem_rd_req}, 32'd0);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R4 resp one cycle", {31'h0, resp_valid}, 32'd0);
    chk("R8 ready after resp", {31'h0, req_ready}, 32'd1);
    chk("R8 busy request ignored", {31'h0, mem_rd_req}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready at reset", {31'h0, req_ready}, 32'd1);
    chk("R1 resp idle at reset", {31'h0, resp_valid}, 32'd0);
    chk("R1 no read at reset", {31'h0, mem_rd_req}, 32'd0);

    // R2, R9: junk in low root bits and entry flag bits, top indices all ones
    load_root(32'h0001_2ABC);
    walk(32'hFFFF_FFFF, 32'h0045_6FFF, 32'h89AB_CFFF, 1, 1, 1'b0);
    // zero indices
    walk(32'h0000_0000, 32'h7000_0001, 32'h1234_5001, 2, 3, 1'b0);
    // R5: directory absent with flag bits set
    walk(32'hABCD_E123, 32'hFFFF_FFFE, 32'h0, 1, 1, 1'b0);
    // R6: leaf absent with flag bits set
    walk(32'h1357_9BDF, 32'h0ABC_D001, 32'hFFFF_FFFE, 1, 2, 1'b0);
    // R7, R8: long latency with a request held during the walk
    walk(32'h8040_2ACE, 32'h0F0F_0001, 32'hCAFE_B001, 30, 25, 1'b1);

    // R7: stray reply while idle
    @(negedge clk);
    mem_rd_valid = 1'b1; mem_rd_data = 32'h5555_5001;
    @(negedge clk);
    mem_rd_valid = 1'b0;
    chk("R7 stray no resp", {31'h0, resp_valid}, 32'd0);
    chk("R7 stray no read", {31'h0, mem_rd_req}, 32'd0);
    chk("R7 stray still ready", {31'h0, req_ready}, 32'd1);

    // R10: new root used by the next walk
    load_root(32'hFEDC_B000);
    walk(32'h0040_1000, 32'h0000_3001, 32'h0000_4001, 1, 1, 1'b0);

    for (int i = 0; i < 40; i++) begin
      logic [31:0] va, e1, e2;
      if (i % 10 == 0) load_root($urandom);
      va = $urandom;
      e1 = $urandom; e1[0] = ($urandom_range(0, 7) != 0);
      e2 = $urandom; e2[0] = ($urandom_range(0, 5) != 0);
      walk(va, e1, e2, $urandom_range(1, 6), $urandom_range(1, 6), 1'(i % 3 == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule